// File: doc/BRIEF.md
# Rewindable Nine-Bit FIFO Buffer

This block is a single-clock first-in/first-out buffer for 9-bit words, each an 8-bit byte plus a parity or control bit. Writes and reads walk circular pointers through the storage, so callers never supply an address. A write request stores one word and a read request delivers the oldest unread word. Requests that would overflow a full buffer or underflow an empty one are dropped. Three registered flags report the state of the buffer: empty, full, and more-than-half-full.

The rewind input moves the read pointer back to location zero and leaves the write pointer where it is. Everything written since the last reset can then be read again, for example to resend a frame after the far end reports an error. The flags are recomputed from the new pointer distance. The rewind only takes effect in a cycle in which neither enable is asserted.

Pulse-driven handshakes are replaced by enables sampled on the rising clock edge. A read-data qualifier stands in for an output bus that is left undriven. The depth is a parameter, normally 512 to 8192 words, and must be a power of two.

Top module: `rtx_fifo`

## Requirements
- R1: While rstN is low, and in the first cycle after it rises, empty is 1, full is 0, halfFull is 0 and rdValid is 0. Both pointers start at location zero, so the first word written after reset is the first word read.
- R2: Words are read in the order they were written. An accepted read drives the word on rdData with rdValid high after the next rising clock edge.
- R3: Starting from reset with no reads, full rises after exactly DEPTH accepted writes. While full is high, a write request is dropped and the stored contents do not change.
- R4: While empty is high, a read request is dropped: rdValid stays low, and no stored or later-written word is lost or skipped.
- R5: halfFull is 1 exactly when the number of stored words is greater than DEPTH/2. All three flags change on the clock edge that accepts the operation which changes the count.
- R6: When read and write are requested in the same cycle, both are accepted if the buffer is neither empty nor full, and the count is left unchanged. When empty, only the write is accepted. When full, only the read is accepted.
- R7: A rewind request with wrEn and rdEn both low returns the read pointer to location zero and leaves the write pointer unchanged. Later reads replay the words from the first one written after reset. This is defined when no more than DEPTH words have been written since the last reset.
- R8: A rewind request in a cycle where wrEn or rdEn is high is ignored. The enabled read or write is still performed normally.
- R9: After an accepted rewind, empty, full and halfFull follow the new distance between the pointers. A drained buffer can become non-empty, half-full or full again.
- R10: rdValid is high only in the cycle after an accepted read. At all other times it is low.
- R11: All nine data bits are stored and returned unchanged, including bit 8 (the most significant bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request, sampled on the clock edge |
| wrData | input | WIDTH (9) | Word to store |
| rdEn | input | 1 | Read request, sampled on the clock edge |
| rewind | input | 1 | Return the read pointer to location zero |
| rdData | output | WIDTH (9) | Word delivered by the last accepted read |
| rdValid | output | 1 | High for the cycle in which rdData carries a fresh word |
| empty | output | 1 | No unread words stored |
| full | output | 1 | DEPTH unread words stored |
| halfFull | output | 1 | More than DEPTH/2 unread words stored |

## Verification
A read and a write can land in the same cycle. The bench requests both while the buffer is partly filled, while it is empty, and while it is full. It judges each case on the returned word, on rdValid, and on the flags, which must reflect an unchanged count, only the write, or only the read. A rewind can also meet an active enable in the same cycle. That case is provoked with a read and again with a write, and the next word read must continue the original sequence rather than restart it. A cycle-by-cycle reference model built on a write history and a read index judges every cycle of these cases and of a long randomized phase.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;

  // Strobes from the pointer control to the storage datapath.
  typedef struct packed {
    logic wrGo;  // store wrData at the write address this edge
    logic rdGo;  // fetch the word at the read address this edge
  } fifo_strobe_t;

endpackage

// File: rtl/rtx_fifo_ctrl.sv
module rtx_fifo_ctrl
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          rewind,
  output fifo_strobe_t  strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          empty,
  output logic          full,
  output logic          halfFull
);

  localparam int         PW     = AW + 1;
  localparam logic [AW:0] DEPTH_V = PW'(DEPTH);
  localparam logic [AW:0] HALF_V  = PW'(DEPTH / 2);

  // Pointers carry one lap bit above the address so full and empty differ.
  logic [AW:0] wrPtr, rdPtr;
  logic [AW:0] wrPtrNxt, rdPtrNxt, fillNxt;
  logic        rewindGo;

  always_comb begin
    strobe.wrGo = wrEn && !full;
    strobe.rdGo = rdEn && !empty;
    rewindGo    = rewind && !wrEn && !rdEn;
    wrPtrNxt    = wrPtr + PW'(strobe.wrGo);
    rdPtrNxt    = rewindGo ? '0 : rdPtr + PW'(strobe.rdGo);
    fillNxt     = wrPtrNxt - rdPtrNxt;
  end

  assign wrAddr = wrPtr[AW-1:0];
  assign rdAddr = rdPtr[AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      empty    <= 1'b1;
      full     <= 1'b0;
      halfFull <= 1'b0;
    end else begin
      wrPtr    <= wrPtrNxt;
      rdPtr    <= rdPtrNxt;
      empty    <= (fillNxt == '0);
      full     <= (fillNxt == DEPTH_V);
      halfFull <= (fillNxt > HALF_V);
    end
  end

  // Occupancy never exceeds the storage (R3).
  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    PW'(wrPtr - rdPtr) <= DEPTH_V);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrEn) |=> $stable(wrPtr));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdEn) |=> $stable(rdPtr));

  assert_flag_sanity_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(empty && full) && !(halfFull && empty));

  assert_rewind_moves_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rewind && !wrEn && !rdEn) |=> (rdPtr == '0) && $stable(wrPtr));

  assert_rewind_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rewind && rdEn && !empty) |=> rdPtr == PW'($past(rdPtr) + 1'b1));

endmodule

// File: rtl/rtx_fifo_store.sv
module rtx_fifo_store
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifo_strobe_t     strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Storage array: no reset, so it maps onto a plain RAM.
  always_ff @(posedge clk) begin
    if (strobe.wrGo) mem[wrAddr] <= wrData;
  end

  // Registered read port; rdData holds its last word between reads.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdGo;
      if (strobe.rdGo) rdData <= mem[rdAddr];
    end
  end

endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  input  logic             rewind,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic             empty,
  output logic             full,
  output logic             halfFull
);

  localparam int AW = $clog2(DEPTH);

  fifo_strobe_t  strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  rtx_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rewind(rewind),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .empty(empty), .full(full), .halfFull(halfFull)
  );

  rtx_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  // A read requested on a non-empty buffer returns data on the next edge (R10).
  assert_valid_after_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !empty) |=> rdValid);

  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && !empty) |=> !rdValid);

endmodule

// File: tb/rtx_fifo_tb.sv
module rtx_fifo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int WIDTH      = 9;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0, rdEn = 1'b0, rewind = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic             rdValid, empty, full, halfFull;

  rtx_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rewind(rewind), .rdData(rdData), .rdValid(rdValid),
    .empty(empty), .full(full), .halfFull(halfFull)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: every word written since reset plus a read index.
  logic [WIDTH-1:0] hist[$];
  int               rdPos = 0;
  logic             expValid = 1'b0;
  logic [WIDTH-1:0] expData = '0;
  int               nChecks = 0;
  int               nFail = 0;
  bit               done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int occ();
    return hist.size() - rdPos;
  endfunction

  task automatic compare();
    chk(empty === (occ() == 0), "R4", int'(empty), int'(occ() == 0));
    chk(full === (occ() == DEPTH), "R3", int'(full), int'(occ() == DEPTH));
    chk(halfFull === (occ() > DEPTH/2), "R5", int'(halfFull), int'(occ() > DEPTH/2));
    chk(rdValid === expValid, "R10", int'(rdValid), int'(expValid));
    if (expValid) chk(rdData === expData, "R2", int'(rdData), int'(expData));
  endtask

  task automatic step(input bit we, input logic [WIDTH-1:0] wd, input bit re, input bit rw);
    bit accW, accR, rwOk;
    @(negedge clk);
    wrEn = we; wrData = wd; rdEn = re; rewind = rw;
    accW = we && (occ() < DEPTH);
    accR = re && (occ() > 0);
    rwOk = rw && !we && !re;
    expValid = accR;
    if (accR) begin
      expData = hist[rdPos];
      rdPos++;
    end
    if (accW) hist.push_back(wd);
    if (rwOk) rdPos = 0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 0; rdEn = 0; rewind = 0;
    repeat (2) @(negedge clk);
    chk(empty && !full && !halfFull && !rdValid, "R1", int'({empty, full, halfFull, rdValid}), 8);
    hist.delete(); rdPos = 0; expValid = 0;
    rstN = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk(empty && !full && !halfFull && !rdValid, "R1", int'({empty, full, halfFull, rdValid}), 8);
  endtask

  task automatic idle(); step(0, '0, 0, 0); endtask

  // Watchdog: a hung run counts as a failure and still reports.
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R3 / R11: fill to exactly DEPTH, extreme bit patterns first.
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) chk(!full, "R3", int'(full), 0);
      step(1, (i == 0) ? 9'h100 : (i == 1) ? 9'h1FF : 9'((i * 37) & 9'h0FF), 0, 0);
    end
    chk(full, "R3", int'(full), 1);
    for (int i = 0; i < 3; i++) step(1, 9'h0AA, 0, 0);
    step(0, '0, 1, 0);
    chk(rdValid && rdData == 9'h100, "R11", int'(rdData), 9'h100);
    step(0, '0, 1, 0);
    chk(rdValid && rdData == 9'h1FF, "R11", int'(rdData), 9'h1FF);
    for (int i = 2; i < DEPTH; i++) step(0, '0, 1, 0);
    for (int i = 0; i < 3; i++) begin
      step(0, '0, 1, 0);
      chk(!rdValid, "R4", int'(rdValid), 0);
    end
    step(1, 9'h055, 0, 0);
    step(0, '0, 1, 0);
    chk(rdValid && rdData == 9'h055, "R3", int'(rdData), 9'h055);

    // R6: simultaneous read and write, mid, empty and full.
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 9'(i + 1), 0, 0);
    for (int i = 0; i < 6; i++) step(1, 9'(i + 20), 1, 0);
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0);
    chk(!empty, "R6", int'(empty), 0);
    step(0, '0, 1, 0);
    chk(empty, "R6", int'(empty), 1);
    step(1, 9'h033, 1, 0);
    chk(!rdValid && !empty, "R6", int'({rdValid, empty}), 0);
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1, 9'(i), 0, 0);
    step(1, 9'h1EE, 1, 0);
    chk(rdValid && !full && rdData == 9'd0, "R6", int'({rdValid, full}), 2);

    // R7 / R9: rewind replays from the first word, flags recomputed.
    do_reset();
    for (int i = 0; i < 10; i++) step(1, 9'(9'h140 + i), 0, 0);
    for (int i = 0; i < 6; i++) step(0, '0, 1, 0);
    chk(!halfFull, "R9", int'(halfFull), 0);
    step(0, '0, 0, 1);
    chk(halfFull && !empty, "R9", int'({halfFull, empty}), 2);
    step(0, '0, 1, 0);
    chk(rdValid && rdData == 9'h140, "R7", int'(rdData), 9'h140);
    for (int i = 1; i < 10; i++) step(0, '0, 1, 0);
    chk(empty, "R7", int'(empty), 1);
    step(0, '0, 0, 1);
    chk(!empty, "R9", int'(empty), 0);
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1, 9'(i + 3), 0, 0);
    for (int i = 0; i < DEPTH; i++) step(0, '0, 1, 0);
    step(0, '0, 0, 1);
    chk(full, "R9", int'(full), 1);

    // R8: rewind with an active enable is ignored.
    do_reset();
    for (int i = 0; i < 6; i++) step(1, 9'(9'h080 + i), 0, 0);
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0);
    step(0, '0, 1, 1);
    chk(rdData == 9'h083, "R8", int'(rdData), 9'h083);
    step(0, '0, 1, 0);
    chk(rdData == 9'h084, "R8", int'(rdData), 9'h084);
    step(1, 9'h0F0, 0, 1);
    step(0, '0, 1, 0);
    chk(rdData == 9'h085, "R8", int'(rdData), 9'h085);

    // Randomized traffic with periodic resets and legal rewinds.
    for (int blk = 0; blk < 6; blk++) begin
      do_reset();
      for (int c = 0; c < 500; c++) begin
        bit we, re, rw;
        we = ($urandom % 100) < ((blk % 2 == 0) ? 60 : 40);
        re = ($urandom % 100) < ((blk % 2 == 0) ? 40 : 60);
        rw = (($urandom % 10) == 0) && (hist.size() <= DEPTH || we || re);
        step(we, 9'($urandom), re, rw);
      end
    end

    idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule